// File: doc/BRIEF.md
# Real-Time Clock Time Keeping, Interrupt and Status Core

This block is the register and event core of a battery-backed real-time clock. It is reached through two bus operations. One loads an index register. The other reads or writes the location that the index selects. The locations hold the current second, minute and hour, three matching alarm fields, four calendar fields that are only stored, two control registers, one interrupt status register that clears when read, and one power status register.

An enable input pulses at 32.768 kHz. A phase counter built on that pulse marks each second. When a second ends, the time fields advance in a single cycle, counting in either BCD or binary. An update-in-progress bit rises a fixed number of base ticks before that moment, so software can see when the time fields are about to change. A second free-running counter drives a periodic event whose period doubles with each step of a four-bit rate code. The periodic, alarm and update-ended flags are each masked by their own enable. Any flag that is set while its enable is set raises a combined request bit and the interrupt output.

Top module: `rtc_ctl`

## Requirements
- R1: After reset, control register A (index 0Ah) reads 26h, control register B (index 0Bh) reads 02h, status register C (index 0Ch) reads 00h, and `irq` is low.
- R2: Each bus access first writes the index register (`idx_wr`, low 6 bits of `bus_wdata`). A data write (`data_wr`) then stores `bus_wdata` at indices 00h to 09h, and `bus_rdata` returns the stored value. Indices 0Eh and above read 00h. Writes to C, to D and to bit 7 of A have no effect.
- R3: Register A bits 6-4 select the divider. Only 010 lets base ticks advance the counters. The codes 110 and 111 clear and hold both counters.
- R4: Register A bits 3-0 hold the rate code r. For r from 3 to 15, the periodic flag sets on every 2^(r-1)-th base tick counted from divider release. Codes 1 and 2 behave as codes 8 and 9. Code 0 never sets the flag.
- R5: Register A bit 7 (update in progress) reads 1 during the last UIP_LEAD base ticks of each SEC_DIV-tick second, and 0 otherwise.
- R6: On the SEC_DIV-th base tick of a second, the seconds field (index 00h) advances. A carry goes into minutes (02h) and then hours (04h), and 23:59:59 wraps to 00:00:00. The same tick sets the update flag.
- R7: With register B bit 2 set, the fields count in plain binary, up to 59 for seconds and minutes and 23 for hours. With bit 2 clear, they count in packed BCD.
- R8: An update sets the alarm flag only when the new second, minute and hour all equal the alarm fields at 01h, 03h and 05h.
- R9: Register C reads {IRQF, PF, AF, UF, 0000} from bit 7 down. IRQF is set when PF with B bit 6, AF with B bit 5, or UF with B bit 4 are both set. `irq` equals IRQF.
- R10: A data read of C clears PF, AF and UF at that clock edge, which drops `irq`. If an event lands in the same cycle as the read, its flag stays set.
- R11: While register B bit 7 is set, no update occurs: time fields and UF do not change on their own, A bit 7 reads 0, and time fields can still be written.
- R12: Register D (index 0Dh) reads 80h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle base tick enable at 32.768 kHz |
| idx_wr | input | 1 | Load index register from bus_wdata |
| data_wr | input | 1 | Write bus_wdata to indexed location |
| data_rd | input | 1 | Read strobe of indexed location (clears C) |
| bus_wdata | input | 8 | Write data / index value |
| bus_rdata | output | 8 | Contents of indexed location |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a read of register C that falls in the same cycle as the last base tick of a second. In that cycle the clear and the update-ended event meet. To get there, the bench holds the divider in reset to fix its phase. It then counts exactly SEC_DIV-1 ticks, loads index C, and raises the read strobe and the base tick together. The read must return the old flags, and a second read must show the update flag still set. Near-exhaustive sweeps across the hour wrap, in both number formats, together with a sweep of every short periodic rate, cover the arithmetic.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = 6;
  localparam int PC_W  = 15;
  localparam int NF    = 10;

  localparam logic [IDX_W-1:0] IX_SEC  = 6'h00;
  localparam logic [IDX_W-1:0] IX_ASEC = 6'h01;
  localparam logic [IDX_W-1:0] IX_MIN  = 6'h02;
  localparam logic [IDX_W-1:0] IX_AMIN = 6'h03;
  localparam logic [IDX_W-1:0] IX_HR   = 6'h04;
  localparam logic [IDX_W-1:0] IX_AHR  = 6'h05;
  localparam logic [IDX_W-1:0] IX_A    = 6'h0A;
  localparam logic [IDX_W-1:0] IX_B    = 6'h0B;
  localparam logic [IDX_W-1:0] IX_C    = 6'h0C;
  localparam logic [IDX_W-1:0] IX_D    = 6'h0D;

  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } flags_t;

  // Encoding of the largest legal value of a field in the active format.
  function automatic logic [DW-1:0] fld_top(input logic [6:0] lim, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = lim / 7'd10;
    ones = lim % 7'd10;
    return bin ? {1'b0, lim} : {tens[3:0], ones[3:0]};
  endfunction

  // Next value of a field, wrapping to zero after its top value.
  function automatic logic [DW-1:0] fld_inc(input logic [DW-1:0] v, input logic [6:0] lim,
                                            input logic bin);
    if (v == fld_top(lim, bin)) return '0;
    if (!bin && v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return v + 8'd1;
  endfunction

  // Mask of the periodic counter bits that must all be one to fire.
  function automatic logic [PC_W-1:0] rate_mask(input logic [3:0] rs);
    logic [3:0] e;
    e = (rs == 4'd1 || rs == 4'd2) ? rs + 4'd7 : rs;
    if (e == 4'd0) return '0;
    return PC_W'((32'd1 << (e - 4'd1)) - 32'd1);
  endfunction
endpackage

// File: rtl/rtc_div.sv
`timescale 1ns/1ps
module rtc_div
  import rtc_pkg::*;
#(
  parameter int SEC_DIV  = 32768,
  parameter int UIP_LEAD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] dv,
  input  logic [3:0] rs,
  input  logic       halt,
  output logic       sec_evt,
  output logic       per_evt,
  output logic       uip
);
  localparam int PH_W = $clog2(SEC_DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SEC_DIV - 1);
  localparam logic [PH_W-1:0] PH_UIP  = PH_W'(SEC_DIV - UIP_LEAD);

  logic            run;
  logic            clr;
  logic [PH_W-1:0] ph;
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] mask;

  assign run  = (dv == 3'b010);
  assign clr  = (dv[2:1] == 2'b11);
  assign mask = rate_mask(rs);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ph <= '0;
      pc <= '0;
    end else if (run && tick) begin
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      pc <= pc + 1'b1;
    end
  end

  assign per_evt = run && tick && (rs != 4'd0) && ((pc & mask) == mask);
  assign sec_evt = run && tick && !halt && (ph == PH_LAST);
  assign uip     = run && !halt && (ph >= PH_UIP);
endmodule

// File: rtl/rtc_time.sv
`timescale 1ns/1ps
module rtc_time
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             sec_evt,
  input  logic             bin,
  output logic [DW-1:0]    rd_val,
  output logic             alarm_evt
);
  logic [DW-1:0] tf [NF];
  logic [DW-1:0] s_n, m_n, h_n, nm, nh;
  logic          c_s, c_m;

  assign c_s = (tf[IX_SEC[3:0]] == fld_top(7'd59, bin));
  assign c_m = (tf[IX_MIN[3:0]] == fld_top(7'd59, bin));
  assign s_n = fld_inc(tf[IX_SEC[3:0]], 7'd59, bin);
  assign m_n = fld_inc(tf[IX_MIN[3:0]], 7'd59, bin);
  assign h_n = fld_inc(tf[IX_HR[3:0]], 7'd23, bin);
  assign nm  = c_s ? m_n : tf[IX_MIN[3:0]];
  assign nh  = (c_s && c_m) ? h_n : tf[IX_HR[3:0]];

  assign alarm_evt = sec_evt && (s_n == tf[IX_ASEC[3:0]]) &&
                     (nm == tf[IX_AMIN[3:0]]) && (nh == tf[IX_AHR[3:0]]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) tf[i] <= '0;
    end else begin
      if (sec_evt) begin
        tf[IX_SEC[3:0]] <= s_n;
        tf[IX_MIN[3:0]] <= nm;
        tf[IX_HR[3:0]]  <= nh;
      end
      if (wr_en && wr_idx < IDX_W'(NF)) tf[wr_idx[3:0]] <= wr_data;
    end
  end

  assign rd_val = (rd_idx < IDX_W'(NF)) ? tf[rd_idx[3:0]] : '0;
endmodule

// File: rtl/rtc_flags.sv
`timescale 1ns/1ps
module rtc_flags
  import rtc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   per_evt,
  input  logic   alarm_evt,
  input  logic   upd_evt,
  input  logic   clr_rd,
  input  flags_t en,
  output flags_t fl,
  output logic   irqf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl <= '0;
    end else begin
      fl.pf <= per_evt   | (fl.pf & ~clr_rd);
      fl.af <= alarm_evt | (fl.af & ~clr_rd);
      fl.uf <= upd_evt   | (fl.uf & ~clr_rd);
    end
  end

  assign irqf = |(fl & en);
endmodule

// File: rtl/rtc_ctl.sv
`timescale 1ns/1ps
module rtc_ctl
  import rtc_pkg::*;
#(
  parameter int SEC_DIV  = 32768,
  parameter int UIP_LEAD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_32k,
  input  logic          idx_wr,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       dv_q;
  logic [3:0]       rs_q;
  logic [DW-1:0]    regb;
  logic             halt;
  logic             sec_evt, per_evt, uip, alarm_evt, c_rd, irqf;
  logic [DW-1:0]    fld_rd;
  flags_t           fl, en;
  logic [2:0]       fl_bits;

  assign halt    = regb[7];
  assign en      = '{pf: regb[6], af: regb[5], uf: regb[4]};
  assign c_rd    = data_rd && (idx_q == IX_C);
  assign fl_bits = fl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      dv_q  <= 3'b010;
      rs_q  <= 4'b0110;
      regb  <= 8'h02;
    end else begin
      if (idx_wr) idx_q <= bus_wdata[IDX_W-1:0];
      if (data_wr && idx_q == IX_A) begin
        dv_q <= bus_wdata[6:4];
        rs_q <= bus_wdata[3:0];
      end
      if (data_wr && idx_q == IX_B) regb <= bus_wdata;
    end
  end

  rtc_div #(.SEC_DIV(SEC_DIV), .UIP_LEAD(UIP_LEAD)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .dv(dv_q), .rs(rs_q), .halt(halt),
    .sec_evt(sec_evt), .per_evt(per_evt), .uip(uip)
  );

  rtc_time u_time (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_idx(idx_q), .wr_data(bus_wdata),
    .rd_idx(idx_q), .sec_evt(sec_evt), .bin(regb[2]), .rd_val(fld_rd),
    .alarm_evt(alarm_evt)
  );

  rtc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .per_evt(per_evt), .alarm_evt(alarm_evt),
    .upd_evt(sec_evt), .clr_rd(c_rd), .en(en), .fl(fl), .irqf(irqf)
  );

  assign irq = irqf;

  always_comb begin
    case (idx_q)
      IX_A:    bus_rdata = {uip, dv_q, rs_q};
      IX_B:    bus_rdata = regb;
      IX_C:    bus_rdata = {irqf, fl.pf, fl.af, fl.uf, 4'b0000};
      IX_D:    bus_rdata = 8'h80;
      default: bus_rdata = fld_rd;
    endcase
  end
endmodule

// File: rtl/rtc_ctl_chk.sv
`timescale 1ns/1ps
module rtc_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_evt,
  input logic       per_evt,
  input logic       uip,
  input logic       halt,
  input logic       c_rd,
  input logic [2:0] fl_bits,
  input logic [3:0] rs_q,
  input logic       irq
);
  a_r6_update_raises_uf: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> fl_bits[0]);
  a_r11_halt_blocks_update: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !sec_evt);
  a_r11_halt_hides_uip: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !uip);
  a_r5_uip_spans_update: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |-> uip);
  a_r4_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_q == 4'd0) |-> !per_evt);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && !sec_evt && !per_evt) |=> (fl_bits == 3'b000));
  a_r10_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && !sec_evt && !per_evt) |=> !irq);
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fl_bits != 3'b000));
endmodule

bind rtc_ctl rtc_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .per_evt(per_evt), .uip(uip),
  .halt(halt), .c_rd(c_rd), .fl_bits(fl_bits), .rs_q(rs_q), .irq(irq)
);

// File: tb/test_rtc_ctl.sv
`timescale 1ns/1ps
module test_rtc_ctl;
  localparam int SD = 64;
  localparam int UL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       idx_wr = 1'b0;
  logic       data_wr = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_ctl #(.SEC_DIV(SD), .UIP_LEAD(UL)) i_rtc_ctl (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .idx_wr(idx_wr), .data_wr(data_wr),
    .data_rd(data_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] ix);
    @(negedge clk); idx_wr = 1'b1; bus_wdata = ix;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] ix, input logic [7:0] v);
    set_idx(ix);
    data_wr = 1'b1; bus_wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ix, output logic [7:0] v);
    set_idx(ix);
    data_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick_32k = 1'b1;
      @(negedge clk); tick_32k = 1'b0;
    end
  endtask

  function automatic logic [7:0] enc(input int x, input bit bin);
    return bin ? 8'(x) : 8'(((x / 10) << 4) | (x % 10));
  endfunction

  task automatic align(input logic [3:0] r);
    wr(8'h0A, {4'h6, r});
    wr(8'h0A, {4'h2, r});
  endtask

  task automatic sweep(input bit bin, input int start, input int n);
    logic [7:0] v;
    wr(8'h0B, bin ? 8'h06 : 8'h02);
    align(4'h0);
    wr(8'h04, enc(start / 3600, bin));
    wr(8'h02, enc((start / 60) % 60, bin));
    wr(8'h00, enc(start % 60, bin));
    for (int k = 1; k <= n; k++) begin
      int t;
      ticks(SD);
      t = (start + k) % 86400;
      rd(8'h00, v); chk(bin ? "R7 binary seconds" : "R6 bcd seconds", v, enc(t % 60, bin));
      rd(8'h02, v); chk(bin ? "R7 binary minutes" : "R6 bcd minutes", v, enc((t / 60) % 60, bin));
      rd(8'h04, v); chk(bin ? "R7 binary hours" : "R6 bcd hours", v, enc(t / 3600, bin));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 180000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R12: reset state
    rd(8'h0A, v); chk("R1 reg A reset", v, 8'h26);
    rd(8'h0B, v); chk("R1 reg B reset", v, 8'h02);
    rd(8'h0C, v); chk("R1 reg C reset", v, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);
    rd(8'h0D, v); chk("R12 reg D", v, 8'h80);

    // R2: storage, unmapped indices, read-only bits
    for (int i = 0; i < 10; i++) wr(8'(i), 8'(i * 23 + 5));
    for (int i = 0; i < 10; i++) begin
      rd(8'(i), v); chk("R2 field readback", v, 8'(i * 23 + 5));
    end
    rd(8'h0E, v); chk("R2 unmapped 0E", v, 8'h00);
    rd(8'h3F, v); chk("R2 unmapped 3F", v, 8'h00);
    wr(8'h0C, 8'hFF); rd(8'h0C, v); chk("R2 C not writable", v, 8'h00);
    wr(8'h0D, 8'h00); rd(8'h0D, v); chk("R2 D not writable", v, 8'h80);
    wr(8'h0A, 8'hA6); rd(8'h0A, v); chk("R2 A bit7 not writable", v, 8'h26);

    // R3: divider held in reset does not advance
    wr(8'h0B, 8'h82);
    wr(8'h0A, 8'h63);
    rd(8'h0C, v);
    ticks(10);
    rd(8'h0C, v); chk("R3 held divider no PF", v & 8'h40, 8'h00);
    rd(8'h0A, v); chk("R3 held divider reg A", v, 8'h63);

    // R4: periodic rate sweep
    for (int r = 1; r <= 9; r++) begin
      int e;
      int p;
      e = (r < 3) ? r + 7 : r;
      p = 1 << (e - 1);
      align(4'(r));
      rd(8'h0C, v);
      ticks(p - 1);
      rd(8'h0C, v); chk("R4 PF before period", v & 8'h40, 8'h00);
      ticks(1);
      rd(8'h0C, v); chk("R4 PF at period", v & 8'h40, 8'h40);
    end
    align(4'h0);
    rd(8'h0C, v);
    ticks(300);
    rd(8'h0C, v); chk("R4 code 0 no PF", v & 8'h40, 8'h00);

    // R9 / R10: periodic interrupt path
    wr(8'h0B, 8'hC2);
    align(4'h3);
    rd(8'h0C, v);
    ticks(4);
    chk("R9 irq with PIE", {7'd0, irq}, 8'h01);
    rd(8'h0C, v); chk("R9 reg C with PIE", v, 8'hC0);
    chk("R10 irq after read", {7'd0, irq}, 8'h00);

    // R5 / R6 / R8 / R9: update window, wrap, alarm
    wr(8'h0B, 8'h22);
    align(4'h0);
    wr(8'h00, 8'h59); wr(8'h02, 8'h59); wr(8'h04, 8'h23);
    wr(8'h01, 8'h00); wr(8'h03, 8'h00); wr(8'h05, 8'h00);
    rd(8'h0C, v);
    ticks(SD - UL - 1);
    rd(8'h0A, v); chk("R5 UIP low before window", v & 8'h80, 8'h00);
    ticks(1);
    rd(8'h0A, v); chk("R5 UIP high in window", v & 8'h80, 8'h80);
    ticks(UL - 1);
    rd(8'h0A, v); chk("R5 UIP high at last tick", v & 8'h80, 8'h80);
    ticks(1);
    rd(8'h0A, v); chk("R5 UIP low after update", v & 8'h80, 8'h00);
    rd(8'h00, v); chk("R6 wrap seconds", v, 8'h00);
    rd(8'h02, v); chk("R6 wrap minutes", v, 8'h00);
    rd(8'h04, v); chk("R6 wrap hours", v, 8'h00);
    chk("R9 irq on alarm", {7'd0, irq}, 8'h01);
    rd(8'h0C, v); chk("R8 alarm and update flags", v, 8'hB0);
    chk("R10 irq cleared by read", {7'd0, irq}, 8'h00);
    ticks(SD);
    chk("R9 no irq without enabled flag", {7'd0, irq}, 8'h00);
    rd(8'h0C, v); chk("R8 no alarm on mismatch", v, 8'h10);

    // R6 / R7: sweeps across the hour wrap
    sweep(1'b0, 23 * 3600 + 58 * 60 + 50, 130);
    sweep(1'b1, 23 * 3600 + 59 * 60 + 20, 70);

    // R10: read of C in the same cycle as the update event
    wr(8'h0B, 8'h02);
    wr(8'h01, 8'h45);
    align(4'h0);
    rd(8'h0C, v);
    ticks(SD - 1);
    set_idx(8'h0C);
    tick_32k = 1'b1; data_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); tick_32k = 1'b0; data_rd = 1'b0;
    chk("R10 colliding read returns old flags", v, 8'h00);
    rd(8'h0C, v); chk("R10 event survives colliding read", v, 8'h10);

    // R11: halt
    wr(8'h0B, 8'h82);
    align(4'h0);
    wr(8'h00, 8'h20);
    rd(8'h0C, v);
    ticks(SD - 2);
    rd(8'h0A, v); chk("R11 no UIP while halted", v, 8'h20);
    ticks(10);
    rd(8'h00, v); chk("R11 seconds frozen", v, 8'h20);
    rd(8'h0C, v); chk("R11 no update flag", v, 8'h00);
    wr(8'h00, 8'h33);
    rd(8'h00, v); chk("R11 write while halted", v, 8'h33);

    finish_run();
  end
endmodule